// File: doc/BRIEF.md
# Dual Transmit/Receive Word FIFO with Level Triggers

This block sits between a CPU register port and a serial shift engine. It holds two FIFOs of 32-bit words, eight entries each. The CPU pushes transmit words with a write strobe, and the engine drains them one by one. The engine deposits received words, and the CPU takes them out with a read strobe. Each FIFO has its own 3-bit trigger code. The code selects an occupancy region. A one-cycle level event fires when the FIFO enters that region.

The block also reports an RX overflow, which happens when a received word finds the RX FIFO full and is thrown away. It reports a TX drain, which happens when the engine takes the last transmit word. Four status flags describe how full or empty each FIFO is. A pointer-reset input empties both FIFOs and holds them empty for as long as it stays high.

The CPU read port keeps the last word it took from the RX FIFO. A read of an empty RX FIFO returns that word again. The CPU write port reads back the last transmit word that was accepted.

Top module: `dual_lvl_fifo`

## Requirements
- R1: Each FIFO returns words in the order they were accepted and holds 8 entries. `eng_tx_data_o` shows the oldest TX word whenever the TX FIFO is not empty. A TX write that meets a full FIFO, with no engine pop in the same cycle, is discarded and the stored words are kept.
- R2: An engine push that meets a full RX FIFO, with no CPU read in the same cycle, is discarded and the stored words are kept. `rx_ovf_evt_o` is then high for exactly the next cycle.
- R3: A CPU read of a non-empty RX FIFO removes the oldest word. From the next cycle, `cpu_rx_rdata_o` shows that word and keeps it until the next read that succeeds. A read of an empty RX FIFO changes neither the output nor the FIFO. After reset the output is 0.
- R4: `cpu_tx_rdata_o` shows the most recent TX word the FIFO accepted, from the cycle after the write. After reset it is 0.
- R5: RX trigger region by occupancy n (code in `rx_lvl_sel_i`):
  - 1: n ≥ 2
  - 2: n ≥ 4
  - 3: n ≥ 6
  - 5: n = 8
  - 7: n ≥ 1
  - 0, 4 and 6 act as code 2.
- R6: TX trigger region by occupancy n (code in `tx_lvl_sel_i`):
  - 1: n ≤ 6
  - 2: n ≤ 4
  - 3: n ≤ 2
  - 5: n = 0
  - 7: n ≤ 7
  - 0, 4 and 6 act as code 2.
- R7: A level event is high in the first cycle in which the current occupancy and code fall inside the region, and low on the cycles that stay inside it. After reset, an empty TX FIFO counts as already inside its region and an empty RX FIFO as outside.
- R8: When an engine pop leaves the TX FIFO empty, with no CPU write in the same cycle, `tx_empty_evt_o` is high for exactly the next cycle.
- R9: The status flags follow the occupancy:
  - `rx_empty_o` is high when the RX FIFO holds 0 words.
  - `rx_not_full_o` is high when the RX FIFO holds fewer than 8 words.
  - `tx_empty_o` and `tx_not_full_o` follow the same rules for the TX FIFO.
  - All four flags are 1 after reset.
- R10: A clock edge with `ptr_rst_i` high leaves both FIFOs empty. Strobes in that cycle are ignored, no overflow or drain event follows, and both data read-back outputs keep their value. Normal operation resumes once the input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ptr_rst_i | input | 1 | Held pointer reset for both FIFOs |
| rx_lvl_sel_i | input | 3 | RX trigger code |
| tx_lvl_sel_i | input | 3 | TX trigger code |
| cpu_tx_wr_i | input | 1 | CPU write strobe to TX FIFO |
| cpu_tx_wdata_i | input | 32 | CPU write word |
| cpu_tx_rdata_o | output | 32 | Last accepted TX word |
| cpu_rx_rd_i | input | 1 | CPU read strobe from RX FIFO |
| cpu_rx_rdata_o | output | 32 | Last word read from RX FIFO |
| eng_tx_pop_i | input | 1 | Engine takes the oldest TX word |
| eng_tx_data_o | output | 32 | Oldest TX word |
| eng_rx_push_i | input | 1 | Engine delivers a received word |
| eng_rx_data_i | input | 32 | Received word |
| rx_lvl_evt_o | output | 1 | RX level event pulse |
| tx_lvl_evt_o | output | 1 | TX level event pulse |
| rx_ovf_evt_o | output | 1 | RX overflow event pulse |
| tx_empty_evt_o | output | 1 | TX drained event pulse |
| rx_not_full_o | output | 1 | RX FIFO below capacity |
| rx_empty_o | output | 1 | RX FIFO empty |
| tx_not_full_o | output | 1 | TX FIFO below capacity |
| tx_empty_o | output | 1 | TX FIFO empty |

## Verification
Directed fills past capacity on each side separate discard-on-full from wrap-around corruption, and show that the overflow pulse is tied to a refused word. Draining past empty separates the repeat of the last read word from a stale or zeroed read port. A sweep of every RX and TX code pair under random strobes confirms each threshold. It also separates a pulse on entry from a level that stays high, and shows that reserved codes fall back to half. Pointer-reset bursts under random traffic, together with full-plus-pop cycles, show that strobes in a flushed cycle are dropped and that a simultaneous pop frees room for a push.

// File: rtl/dual_lvl_fifo_pkg.sv
package dual_lvl_fifo_pkg;
  typedef enum logic [2:0] {
    LVL_RSV0 = 3'd0,
    LVL_Q1   = 3'd1,
    LVL_HALF = 3'd2,
    LVL_Q3   = 3'd3,
    LVL_RSV4 = 3'd4,
    LVL_EDGE = 3'd5,
    LVL_RSV6 = 3'd6,
    LVL_ONE  = 3'd7
  } lvl_code_e;

  typedef enum logic {
    SIDE_RX = 1'b0,
    SIDE_TX = 1'b1
  } side_e;
endpackage

// File: rtl/dlf_fifo.sv
module dlf_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] cnt_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          push_ok_o,
  output logic          pop_ok_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full_o    = (cnt_q == FULL_CNT);
  assign empty_o   = (cnt_q == '0);
  assign cnt_o     = cnt_q;
  assign head_o    = mem_q[rd_ptr_q];
  assign pop_ok_o  = pop_i && !empty_o && !flush_i;
  // a pop in the same cycle frees the slot a full fifo needs
  assign push_ok_o = push_i && (!full_o || pop_ok_o) && !flush_i;

  always_ff @(posedge clk_i) begin
    if (push_ok_o) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok_o) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_ok_o)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_ok_o, pop_ok_o})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/dlf_lvl_trig.sv
module dlf_lvl_trig
  import dual_lvl_fifo_pkg::*;
#(
  parameter side_e SIDE  = SIDE_RX,
  parameter int    DEPTH = 8,
  parameter int    CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    code_i,
  input  logic [CW-1:0] cnt_i,
  output logic          evt_o
);
  localparam logic [CW-1:0] TH_Q1   = CW'(DEPTH / 4);
  localparam logic [CW-1:0] TH_HALF = CW'(DEPTH / 2);
  localparam logic [CW-1:0] TH_Q3   = CW'((3 * DEPTH) / 4);
  localparam logic [CW-1:0] TH_FULL = CW'(DEPTH);
  // empty fifo sits inside every TX region and outside every RX region
  localparam logic HIT_RST = (SIDE == SIDE_TX);

  logic hit, hit_q;

  generate
    if (SIDE == SIDE_RX) begin : g_rx
      always_comb begin
        case (lvl_code_e'(code_i))
          LVL_Q1:   hit = (cnt_i >= TH_Q1);
          LVL_Q3:   hit = (cnt_i >= TH_Q3);
          LVL_EDGE: hit = (cnt_i == TH_FULL);
          LVL_ONE:  hit = (cnt_i != '0);
          default:  hit = (cnt_i >= TH_HALF);
        endcase
      end
    end else begin : g_tx
      always_comb begin
        case (lvl_code_e'(code_i))
          LVL_Q1:   hit = (cnt_i <= TH_Q3);
          LVL_Q3:   hit = (cnt_i <= TH_Q1);
          LVL_EDGE: hit = (cnt_i == '0);
          LVL_ONE:  hit = (cnt_i != TH_FULL);
          default:  hit = (cnt_i <= TH_HALF);
        endcase
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_q <= HIT_RST;
    else         hit_q <= hit;
  end

  assign evt_o = hit && !hit_q;
endmodule

// File: rtl/dual_lvl_fifo.sv
module dual_lvl_fifo
  import dual_lvl_fifo_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ptr_rst_i,
  input  logic [2:0]    rx_lvl_sel_i,
  input  logic [2:0]    tx_lvl_sel_i,
  input  logic          cpu_tx_wr_i,
  input  logic [DW-1:0] cpu_tx_wdata_i,
  output logic [DW-1:0] cpu_tx_rdata_o,
  input  logic          cpu_rx_rd_i,
  output logic [DW-1:0] cpu_rx_rdata_o,
  input  logic          eng_tx_pop_i,
  output logic [DW-1:0] eng_tx_data_o,
  input  logic          eng_rx_push_i,
  input  logic [DW-1:0] eng_rx_data_i,
  output logic          rx_lvl_evt_o,
  output logic          tx_lvl_evt_o,
  output logic          rx_ovf_evt_o,
  output logic          tx_empty_evt_o,
  output logic          rx_not_full_o,
  output logic          rx_empty_o,
  output logic          tx_not_full_o,
  output logic          tx_empty_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] ONE_LEFT = CW'(1);

  logic [DW-1:0] rx_head;
  logic [CW-1:0] rx_cnt, tx_cnt;
  logic          rx_full, rx_empty, rx_push_ok, rx_pop_ok;
  logic          tx_full, tx_empty, tx_push_ok, tx_pop_ok;
  logic [DW-1:0] rx_last_q, tx_last_q;
  logic          ovf_q, drain_q;

  dlf_fifo #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_tx_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (ptr_rst_i),
    .push_i    (cpu_tx_wr_i),
    .data_i    (cpu_tx_wdata_i),
    .pop_i     (eng_tx_pop_i),
    .head_o    (eng_tx_data_o),
    .cnt_o     (tx_cnt),
    .full_o    (tx_full),
    .empty_o   (tx_empty),
    .push_ok_o (tx_push_ok),
    .pop_ok_o  (tx_pop_ok)
  );

  dlf_fifo #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_rx_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (ptr_rst_i),
    .push_i    (eng_rx_push_i),
    .data_i    (eng_rx_data_i),
    .pop_i     (cpu_rx_rd_i),
    .head_o    (rx_head),
    .cnt_o     (rx_cnt),
    .full_o    (rx_full),
    .empty_o   (rx_empty),
    .push_ok_o (rx_push_ok),
    .pop_ok_o  (rx_pop_ok)
  );

  dlf_lvl_trig #(.SIDE(SIDE_RX), .DEPTH(DEPTH), .CW(CW)) u_rx_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .code_i (rx_lvl_sel_i),
    .cnt_i  (rx_cnt),
    .evt_o  (rx_lvl_evt_o)
  );

  dlf_lvl_trig #(.SIDE(SIDE_TX), .DEPTH(DEPTH), .CW(CW)) u_tx_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .code_i (tx_lvl_sel_i),
    .cnt_i  (tx_cnt),
    .evt_o  (tx_lvl_evt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_last_q <= '0;
      tx_last_q <= '0;
      ovf_q     <= 1'b0;
      drain_q   <= 1'b0;
    end else begin
      if (rx_pop_ok)  rx_last_q <= rx_head;
      if (tx_push_ok) tx_last_q <= cpu_tx_wdata_i;
      // refused push outside a flush can only mean a full fifo
      ovf_q   <= eng_rx_push_i && !rx_push_ok && !ptr_rst_i;
      drain_q <= tx_pop_ok && !tx_push_ok && (tx_cnt == ONE_LEFT);
    end
  end

  assign cpu_rx_rdata_o = rx_last_q;
  assign cpu_tx_rdata_o = tx_last_q;
  assign rx_ovf_evt_o   = ovf_q;
  assign tx_empty_evt_o = drain_q;
  assign rx_not_full_o  = !rx_full;
  assign rx_empty_o     = rx_empty;
  assign tx_not_full_o  = !tx_full;
  assign tx_empty_o     = tx_empty;
endmodule

// File: rtl/dual_lvl_fifo_chk.sv
module dual_lvl_fifo_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ptr_rst_i,
  input logic        cpu_tx_wr_i,
  input logic        cpu_rx_rd_i,
  input logic        eng_rx_push_i,
  input logic [31:0] cpu_rx_rdata_o,
  input logic        rx_ovf_evt_o,
  input logic        rx_lvl_evt_o,
  input logic        tx_lvl_evt_o,
  input logic        tx_empty_evt_o,
  input logic        rx_not_full_o,
  input logic        rx_empty_o,
  input logic        tx_not_full_o,
  input logic        tx_empty_o
);
  // R2
  ovf_on_refused_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_rx_push_i && !rx_not_full_o && !cpu_rx_rd_i && !ptr_rst_i) |=> rx_ovf_evt_o);

  // R2
  ovf_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ovf_evt_o |-> $past(eng_rx_push_i && !rx_not_full_o && !cpu_rx_rd_i));

  // R3
  empty_read_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_rx_rd_i && rx_empty_o) |=> $stable(cpu_rx_rdata_o));

  // R7
  rx_lvl_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_lvl_evt_o |=> !rx_lvl_evt_o);

  // R7
  tx_lvl_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_lvl_evt_o |=> !tx_lvl_evt_o);

  // R8
  drain_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_evt_o |-> (tx_empty_o && !$past(cpu_tx_wr_i)));

  // R9
  rx_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_empty_o |-> rx_not_full_o);

  // R9
  tx_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> tx_not_full_o);

  // R10
  flush_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_rst_i |=> (rx_empty_o && tx_empty_o && !rx_ovf_evt_o && !tx_empty_evt_o));
endmodule

bind dual_lvl_fifo dual_lvl_fifo_chk u_chk (.*);

// File: tb/dual_lvl_fifo_tb.sv
module dual_lvl_fifo_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ptr_rst_i = 1'b0;
  logic [2:0]  rx_lvl_sel_i = 3'd2;
  logic [2:0]  tx_lvl_sel_i = 3'd2;
  logic        cpu_tx_wr_i = 1'b0;
  logic [31:0] cpu_tx_wdata_i = '0;
  logic [31:0] cpu_tx_rdata_o;
  logic        cpu_rx_rd_i = 1'b0;
  logic [31:0] cpu_rx_rdata_o;
  logic        eng_tx_pop_i = 1'b0;
  logic [31:0] eng_tx_data_o;
  logic        eng_rx_push_i = 1'b0;
  logic [31:0] eng_rx_data_i = '0;
  logic        rx_lvl_evt_o, tx_lvl_evt_o, rx_ovf_evt_o, tx_empty_evt_o;
  logic        rx_not_full_o, rx_empty_o, tx_not_full_o, tx_empty_o;

  dual_lvl_fifo u_dut (.*);

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;

  // reference model
  logic [31:0] rxq[$];
  logic [31:0] txq[$];
  logic [31:0] m_rx_last = '0, m_tx_last = '0;
  bit m_ovf = 0, m_drain = 0, m_rx_prev = 0, m_tx_prev = 1, m_flushed = 0;

  function automatic bit rx_region(int n, int code);
    case (code)
      1: return n >= 2;
      3: return n >= 6;
      5: return n == 8;
      7: return n >= 1;
      default: return n >= 4;
    endcase
  endfunction

  function automatic bit tx_region(int n, int code);
    case (code)
      1: return n <= 6;
      3: return n <= 2;
      5: return n == 0;
      7: return n <= 7;
      default: return n <= 4;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      rxq.delete(); txq.delete();
      m_rx_last = '0; m_tx_last = '0;
      m_ovf = 0; m_drain = 0; m_rx_prev = 0; m_tx_prev = 1; m_flushed = 0;
    end else begin
      int rn, tn;
      bit tpop, tpush, rrd, rpush;
      rn = rxq.size(); tn = txq.size();
      m_rx_prev = rx_region(rn, int'(rx_lvl_sel_i));
      m_tx_prev = tx_region(tn, int'(tx_lvl_sel_i));
      m_flushed = ptr_rst_i;
      if (ptr_rst_i) begin
        rxq.delete(); txq.delete();
        m_ovf = 0; m_drain = 0;
      end else begin
        tpop  = eng_tx_pop_i && tn > 0;
        tpush = cpu_tx_wr_i && (tn < 8 || tpop);
        m_drain = tpop && !tpush && tn == 1;
        if (tpop) void'(txq.pop_front());
        if (tpush) begin txq.push_back(cpu_tx_wdata_i); m_tx_last = cpu_tx_wdata_i; end
        rrd   = cpu_rx_rd_i && rn > 0;
        rpush = eng_rx_push_i && (rn < 8 || rrd);
        m_ovf = eng_rx_push_i && !rpush;
        if (rrd) m_rx_last = rxq.pop_front();
        if (rpush) rxq.push_back(eng_rx_data_i);
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      int rn, tn;
      bit rexp, texp;
      rn = rxq.size(); tn = txq.size();
      chk(rx_empty_o == (rn == 0), "R9 rx_empty", rx_empty_o, rn == 0);
      chk(rx_not_full_o == (rn < 8), "R9 rx_not_full", rx_not_full_o, rn < 8);
      chk(tx_empty_o == (tn == 0), "R9 tx_empty", tx_empty_o, tn == 0);
      chk(tx_not_full_o == (tn < 8), "R9 tx_not_full", tx_not_full_o, tn < 8);
      chk(cpu_rx_rdata_o == m_rx_last, "R3 rx read port", cpu_rx_rdata_o, m_rx_last);
      chk(cpu_tx_rdata_o == m_tx_last, "R4 tx readback", cpu_tx_rdata_o, m_tx_last);
      if (tn > 0) chk(eng_tx_data_o == txq[0], "R1 tx order", eng_tx_data_o, txq[0]);
      chk(rx_ovf_evt_o == m_ovf, "R2 overflow event", rx_ovf_evt_o, m_ovf);
      chk(tx_empty_evt_o == m_drain, "R8 drain event", tx_empty_evt_o, m_drain);
      rexp = rx_region(rn, int'(rx_lvl_sel_i)) && !m_rx_prev;
      texp = tx_region(tn, int'(tx_lvl_sel_i)) && !m_tx_prev;
      chk(rx_lvl_evt_o == rexp, "R5 R7 rx level event", rx_lvl_evt_o, rexp);
      chk(tx_lvl_evt_o == texp, "R6 R7 tx level event", tx_lvl_evt_o, texp);
      if (m_flushed) chk(rx_empty_o && tx_empty_o, "R10 flush", {rx_empty_o, tx_empty_o}, 2'b11);
    end
  end

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic idle();
    cpu_tx_wr_i = 0; cpu_rx_rd_i = 0; eng_tx_pop_i = 0; eng_rx_push_i = 0; ptr_rst_i = 0;
  endtask

  task automatic rand_traffic(input int n, input int pct);
    for (int i = 0; i < n; i++) begin
      cpu_tx_wr_i    = ($urandom % 100) < pct;
      eng_tx_pop_i   = ($urandom % 100) < (100 - pct);
      eng_rx_push_i  = ($urandom % 100) < pct;
      cpu_rx_rd_i    = ($urandom % 100) < (100 - pct);
      cpu_tx_wdata_i = $urandom;
      eng_rx_data_i  = $urandom;
      tick();
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    @(negedge clk_i); #1;
    // R9 R4 R3 reset values
    chk(rx_empty_o && rx_not_full_o && tx_empty_o && tx_not_full_o, "R9 reset flags",
        {rx_empty_o, rx_not_full_o, tx_empty_o, tx_not_full_o}, 4'hf);
    chk(cpu_tx_rdata_o == 0, "R4 reset readback", cpu_tx_rdata_o, 0);
    chk(cpu_rx_rdata_o == 0, "R3 reset read port", cpu_rx_rdata_o, 0);
    tick();

    // R1: overfill TX then drain past empty
    for (int i = 0; i < 10; i++) begin cpu_tx_wr_i = 1; cpu_tx_wdata_i = 32'h100 + i; tick(); end
    idle();
    tick();
    chk(!tx_not_full_o, "R1 tx full after overfill", tx_not_full_o, 0);
    for (int i = 0; i < 10; i++) begin eng_tx_pop_i = 1; tick(); end
    idle(); tick();

    // R2 R3: overfill RX then read past empty
    for (int i = 0; i < 10; i++) begin eng_rx_push_i = 1; eng_rx_data_i = 32'h200 + i; tick(); end
    idle(); tick();
    for (int i = 0; i < 10; i++) begin cpu_rx_rd_i = 1; tick(); end
    idle(); tick();
    chk(cpu_rx_rdata_o == 32'h207, "R3 empty read repeats", cpu_rx_rdata_o, 32'h207);

    // R1 R2: full with simultaneous pop accepts push
    for (int i = 0; i < 8; i++) begin eng_rx_push_i = 1; cpu_tx_wr_i = 1; eng_rx_data_i = i; cpu_tx_wdata_i = i; tick(); end
    eng_rx_push_i = 1; cpu_rx_rd_i = 1; cpu_tx_wr_i = 1; eng_tx_pop_i = 1;
    repeat (4) tick();
    idle(); tick();

    // R5 R6 R7: every code pair
    for (int rc = 0; rc < 8; rc++) begin
      for (int tc = 0; tc < 8; tc++) begin
        rx_lvl_sel_i = rc[2:0]; tx_lvl_sel_i = tc[2:0];
        rand_traffic(30, 70);
        rand_traffic(30, 30);
      end
    end
    idle();

    // R10: flush bursts under traffic
    for (int k = 0; k < 20; k++) begin
      rand_traffic(12, 65);
      ptr_rst_i = 1;
      for (int j = 0; j < 3; j++) begin
        cpu_tx_wr_i = 1; eng_rx_push_i = 1; cpu_rx_rd_i = 1; eng_tx_pop_i = 1;
        tick();
      end
      ptr_rst_i = 0;
    end
    idle();
    rand_traffic(200, 50);
    idle(); repeat (3) tick();

    summary();
    $finish;
  end
endmodule